// File: doc/BRIEF.md
# Load/Store Byte-Lane Alignment Unit

This block sits between a 32-bit integer pipeline and a memory port that reads whole words and writes with per-byte enables. For each request it adds a sign-extended 16-bit offset to a base value to form the effective address. For a store it copies the source data into the right byte lanes and raises the matching write enables. For a load it picks the addressed byte, halfword or word out of the returned word and widens it to 32 bits, with sign or zero fill. Byte order is big-endian: byte offset 0 is bits 31:24 of the memory word.

Requests enter through a valid/ready stream. A request is taken when `req_valid` and `req_ready` are both high at a rising clock edge. `req_ready` is high only when the response slot is free, meaning no response is held or the held one is being taken in the same cycle. An aligned request also needs `mem_ready`. A misaligned halfword or word access never reaches memory. It is consumed and answered with a flagged response.

Every accepted request gets exactly one response, one cycle later, on a second valid/ready stream. A response held by a low `rsp_ready` stays unchanged until it is taken. Load data from memory is valid only in the cycle after the read is accepted. The block keeps a copy of it, so back-pressure on the response never loses the data.

Top module: `lane_align_unit`

## Requirements
- R1: The effective address is `req_base` plus `req_offset` sign-extended to 32 bits. `mem_addr` carries this address with bits 1:0 forced to zero.
- R2: `req_size` encodes 00 as byte, 01 as halfword, and 10 or 11 as word. On a store, `mem_be` bit j enables `mem_wdata` bits 8j+7:8j, so bit 3 is byte offset 0. A byte store at offset k enables only the lane of offset k. A halfword store enables the two lanes of its halfword. A word store enables all four lanes. This gives exactly 1, 2 or 4 set bits.
- R3: On a store, the byte is copied into all four lanes (`{4{wdata[7:0]}}`), the halfword into both halves (`{2{wdata[15:0]}}`), and a word is passed unchanged.
- R4: A load with `req_unsigned` low returns the selected byte or halfword sign-extended to 32 bits. Byte offset k is taken from bits 31-8k:24-8k, and a halfword at offset 0 or 2 from bits 31:16 or 15:0.
- R5: A byte or halfword load with `req_unsigned` high returns the selected bits zero-extended to 32 bits.
- R6: A word load returns the whole memory word unchanged.
- R7: A halfword access with address bit 0 set, or a word access with address bits 1:0 nonzero, is misaligned. It raises no `mem_valid` and writes nothing. Its response has `rsp_misalign` high and `rsp_data` zero.
- R8: Every accepted request gives `rsp_valid` high in the next cycle. Load data comes from `mem_rdata` in the cycle after the read was accepted. A store response has `rsp_data` zero and `rsp_misalign` low.
- R9: While `rsp_valid` is high and `rsp_ready` is low, the next cycle shows the same response unchanged, whatever `mem_rdata` does meanwhile.
- R10: `mem_valid` is high exactly when `req_valid` is high, the request is aligned and the response slot is free. `req_ready` is high exactly when the slot is free and either the request is misaligned or `mem_ready` is high. `mem_write` follows `req_store`.
- R11: After reset, `rsp_valid` and `mem_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request taken at this edge when valid |
| req_store | input | 1 | 1 = store, 0 = load |
| req_size | input | 2 | Access size: 00 byte, 01 halfword, 1x word |
| req_unsigned | input | 1 | Zero-extend sub-word load |
| req_base | input | 32 | Base value |
| req_offset | input | 16 | Signed displacement |
| req_wdata | input | 32 | Store source data |
| mem_valid | output | 1 | Memory access request |
| mem_ready | input | 1 | Memory accepts the access |
| mem_write | output | 1 | Access is a write |
| mem_addr | output | 32 | Word-aligned byte address |
| mem_be | output | 4 | Per-byte write enables (zero on reads) |
| mem_wdata | output | 32 | Lane-steered write data |
| mem_rdata | input | 32 | Read word, valid the cycle after a read is accepted |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_data | output | 32 | Extended load result, zero otherwise |
| rsp_misalign | output | 1 | Access was misaligned |

## Verification
The case most likely to break is a response being drained while a new request is accepted in the same cycle. The previous load's data is then still coming straight from the memory port while the next access is already being issued. The bench provokes this by dropping `rsp_ready` across a load and releasing it in the same cycle that a further load or store is presented. A behavioural model then checks that the held word comes out intact, the new request goes to memory, and its response follows one cycle later. A misaligned request arriving in the same cycle as a drain is judged the same way: there must be no memory access and a flagged response on the next cycle.

// File: rtl/lsu_align_pkg.sv
package lsu_align_pkg;

  typedef enum logic [1:0] {
    ACC_BYTE     = 2'b00,
    ACC_HALF     = 2'b01,
    ACC_WORD     = 2'b10,
    ACC_WORD_ALT = 2'b11
  } acc_size_e;

  function automatic logic is_sub_word(acc_size_e s);
    return (s == ACC_BYTE) || (s == ACC_HALF);
  endfunction

endpackage

// File: rtl/lsu_ea_calc.sv
module lsu_ea_calc
  import lsu_align_pkg::*;
#(
  parameter int XLEN = 32,
  parameter int OFFW = 16,
  localparam int LANES = XLEN / 8,
  localparam int LW = $clog2(LANES)
) (
  input  logic [XLEN-1:0] base_i,
  input  logic [OFFW-1:0] offset_i,
  input  acc_size_e       size_i,
  output logic [XLEN-1:0] ea_o,
  output logic [LW-1:0]   lane_o,
  output logic            misalign_o
);

  logic [XLEN-1:0] off_ext;

  assign off_ext = {{(XLEN-OFFW){offset_i[OFFW-1]}}, offset_i};
  assign ea_o    = base_i + off_ext;
  assign lane_o  = ea_o[LW-1:0];

  always_comb begin
    case (size_i)
      ACC_BYTE: misalign_o = 1'b0;
      ACC_HALF: misalign_o = ea_o[0];
      default:  misalign_o = |ea_o[LW-1:0];
    endcase
  end

endmodule

// File: rtl/lsu_store_steer.sv
module lsu_store_steer
  import lsu_align_pkg::*;
#(
  parameter int XLEN = 32,
  localparam int LANES = XLEN / 8,
  localparam int LW = $clog2(LANES)
) (
  input  acc_size_e        size_i,
  input  logic [LW-1:0]    lane_i,
  input  logic [XLEN-1:0]  wdata_i,
  output logic [LANES-1:0] be_o,
  output logic [XLEN-1:0]  data_o
);

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    localparam int HI = XLEN - 1 - 8 * i;
    logic hit_byte;
    logic hit_half;

    assign hit_byte = (lane_i == LW'(i));
    assign hit_half = (lane_i[LW-1:1] == (LW-1)'(i / 2));

    always_comb begin
      case (size_i)
        ACC_BYTE: begin
          be_o[LANES-1-i]  = hit_byte;
          data_o[HI -: 8]  = wdata_i[7:0];
        end
        ACC_HALF: begin
          be_o[LANES-1-i]  = hit_half;
          data_o[HI -: 8]  = (i % 2 == 0) ? wdata_i[15:8] : wdata_i[7:0];
        end
        default: begin
          be_o[LANES-1-i]  = 1'b1;
          data_o[HI -: 8]  = wdata_i[HI -: 8];
        end
      endcase
    end
  end

endmodule

// File: rtl/lsu_load_extract.sv
module lsu_load_extract
  import lsu_align_pkg::*;
#(
  parameter int XLEN = 32,
  localparam int LANES = XLEN / 8,
  localparam int LW = $clog2(LANES)
) (
  input  logic [XLEN-1:0] word_i,
  input  acc_size_e       size_i,
  input  logic [LW-1:0]   lane_i,
  input  logic            unsigned_i,
  output logic [XLEN-1:0] result_o
);

  logic [7:0]  lane_b [LANES];
  logic [7:0]  sel_b;
  logic [15:0] sel_h;
  logic [LW-1:0] h_even;
  logic [LW-1:0] h_odd;

  for (genvar i = 0; i < LANES; i++) begin : g_split
    assign lane_b[i] = word_i[XLEN-1-8*i -: 8];
  end

  assign h_even = {lane_i[LW-1:1], 1'b0};
  assign h_odd  = {lane_i[LW-1:1], 1'b1};
  assign sel_b  = lane_b[lane_i];
  assign sel_h  = {lane_b[h_even], lane_b[h_odd]};

  always_comb begin
    case (size_i)
      ACC_BYTE: result_o = {{(XLEN-8){~unsigned_i & sel_b[7]}}, sel_b};
      ACC_HALF: result_o = {{(XLEN-16){~unsigned_i & sel_h[15]}}, sel_h};
      default:  result_o = word_i;
    endcase
  end

endmodule

// File: rtl/lane_align_unit.sv
module lane_align_unit
  import lsu_align_pkg::*;
#(
  parameter int XLEN = 32,
  parameter int OFFW = 16,
  localparam int LANES = XLEN / 8,
  localparam int LW = $clog2(LANES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic             req_store,
  input  logic [1:0]       req_size,
  input  logic             req_unsigned,
  input  logic [XLEN-1:0]  req_base,
  input  logic [OFFW-1:0]  req_offset,
  input  logic [XLEN-1:0]  req_wdata,
  output logic             mem_valid,
  input  logic             mem_ready,
  output logic             mem_write,
  output logic [XLEN-1:0]  mem_addr,
  output logic [LANES-1:0] mem_be,
  output logic [XLEN-1:0]  mem_wdata,
  input  logic [XLEN-1:0]  mem_rdata,
  output logic             rsp_valid,
  input  logic             rsp_ready,
  output logic [XLEN-1:0]  rsp_data,
  output logic             rsp_misalign
);

  acc_size_e        size_in;
  logic [XLEN-1:0]  ea;
  logic [LW-1:0]    lane;
  logic             mis;
  logic [LANES-1:0] st_be;
  logic [XLEN-1:0]  st_data;
  logic             slot_free;
  logic             accept;

  // response stage state
  logic             rv_q;
  logic             fresh_q;
  logic             p_load_q;
  logic             p_mis_q;
  logic             p_uns_q;
  acc_size_e        p_size_q;
  logic [LW-1:0]    p_lane_q;
  logic [XLEN-1:0]  held_q;
  logic [XLEN-1:0]  ext_data;

  assign size_in = acc_size_e'(req_size);

  lsu_ea_calc #(.XLEN(XLEN), .OFFW(OFFW)) u_ea (
    .base_i     (req_base),
    .offset_i   (req_offset),
    .size_i     (size_in),
    .ea_o       (ea),
    .lane_o     (lane),
    .misalign_o (mis)
  );

  lsu_store_steer #(.XLEN(XLEN)) u_st (
    .size_i  (size_in),
    .lane_i  (lane),
    .wdata_i (req_wdata),
    .be_o    (st_be),
    .data_o  (st_data)
  );

  lsu_load_extract #(.XLEN(XLEN)) u_ld (
    .word_i     (mem_rdata),
    .size_i     (p_size_q),
    .lane_i     (p_lane_q),
    .unsigned_i (p_uns_q),
    .result_o   (ext_data)
  );

  // request side handshake
  assign slot_free = !rv_q || rsp_ready;
  assign mem_valid = req_valid && slot_free && !mis;
  assign req_ready = slot_free && (mis || mem_ready);
  assign accept    = req_valid && req_ready;

  assign mem_write = req_store;
  assign mem_addr  = {ea[XLEN-1:LW], LW'(0)};
  assign mem_be    = req_store ? st_be : '0;
  assign mem_wdata = st_data;

  // response stage: the read word is live only in the cycle after
  // acceptance, so it is copied into held_q if the consumer stalls
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rv_q     <= 1'b0;
      fresh_q  <= 1'b0;
      p_load_q <= 1'b0;
      p_mis_q  <= 1'b0;
      p_uns_q  <= 1'b0;
      p_size_q <= ACC_WORD;
      p_lane_q <= '0;
      held_q   <= '0;
    end else if (accept) begin
      rv_q     <= 1'b1;
      fresh_q  <= 1'b1;
      p_load_q <= !req_store;
      p_mis_q  <= mis;
      p_uns_q  <= req_unsigned;
      p_size_q <= size_in;
      p_lane_q <= lane;
    end else if (rv_q && rsp_ready) begin
      rv_q    <= 1'b0;
      fresh_q <= 1'b0;
    end else if (fresh_q) begin
      held_q  <= ext_data;
      fresh_q <= 1'b0;
    end
  end

  assign rsp_valid    = rv_q;
  assign rsp_misalign = p_mis_q;
  assign rsp_data     = (p_load_q && !p_mis_q) ? (fresh_q ? ext_data : held_q) : '0;

  // R8: one response per accepted request, one cycle later
  p_rsp_follows_r8: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> rsp_valid);

  // R9: a stalled response does not change
  p_rsp_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data) && $stable(rsp_misalign)));

  // R7: misaligned acceptance is answered with the flag
  p_mis_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && mis) |=> (rsp_misalign && rsp_data == '0));

  // R2: store enables count 1, 2 or all lanes
  p_be_count_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && mem_write) |->
      ($countones(mem_be) == 1 || $countones(mem_be) == 2 || $countones(mem_be) == LANES));

  // R10: no memory access without a request
  p_mem_needs_req_r10: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid |-> req_valid);

  // R5: unsigned byte loads have clear upper bits
  p_uext_byte_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && p_load_q && p_uns_q && p_size_q == ACC_BYTE) |-> (rsp_data[XLEN-1:8] == '0));

endmodule

// File: tb/sim_lane_align_unit.sv
module sim_lane_align_unit;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_store = 1'b0;
  logic [1:0]  req_size = 2'b10;
  logic        req_unsigned = 1'b0;
  logic [31:0] req_base = '0;
  logic [15:0] req_offset = '0;
  logic [31:0] req_wdata = '0;
  logic        mem_valid;
  logic        mem_ready = 1'b1;
  logic        mem_write;
  logic [31:0] mem_addr;
  logic [3:0]  mem_be;
  logic [31:0] mem_wdata;
  logic [31:0] mem_rdata = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b1;
  logic [31:0] rsp_data;
  logic        rsp_misalign;

  always #(CLK_PERIOD/2) clk = ~clk;

  lane_align_unit u0 (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_store(req_store),
    .req_size(req_size), .req_unsigned(req_unsigned), .req_base(req_base),
    .req_offset(req_offset), .req_wdata(req_wdata),
    .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_write(mem_write),
    .mem_addr(mem_addr), .mem_be(mem_be), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data),
    .rsp_misalign(rsp_misalign)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  logic [31:0] mem_m [16];
  bit          q_mis [$];
  logic [31:0] q_data [$];
  string       q_tag [$];
  bit          hold_prev = 0;
  logic [31:0] prev_data = '0;
  bit          prev_mis = 0;
  bit          rd_pend = 0;
  logic [31:0] rd_word = '0;
  bit          last_acc = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int nbytes(input logic [1:0] s);
    if (s == 2'b00) return 1;
    if (s == 2'b01) return 2;
    return 4;
  endfunction

  function automatic logic [31:0] ref_ea(input logic [31:0] b, input logic [15:0] o);
    return b + {{16{o[15]}}, o};
  endfunction

  function automatic bit ref_mis(input logic [31:0] ea, input logic [1:0] s);
    return (int'(ea[1:0]) % nbytes(s)) != 0;
  endfunction

  function automatic logic [3:0] ref_be(input logic [31:0] ea, input logic [1:0] s);
    logic [3:0] be;
    int k;
    int n;
    n = nbytes(s);
    k = int'(ea[1:0]);
    for (int i = 0; i < 4; i++) be[3-i] = (i >= k) && (i < k + n);
    return be;
  endfunction

  function automatic logic [31:0] ref_wdata(input logic [31:0] d, input logic [1:0] s);
    if (s == 2'b00) return {4{d[7:0]}};
    if (s == 2'b01) return {2{d[15:0]}};
    return d;
  endfunction

  function automatic logic [31:0] ref_load(input logic [31:0] w, input logic [31:0] ea,
                                           input logic [1:0] s, input bit u);
    logic [31:0] v;
    logic [31:0] m;
    int n;
    n = nbytes(s);
    v = (w << (8 * int'(ea[1:0]))) >> (32 - 8 * n);
    if (n < 4) begin
      m = (32'h1 << (8 * n)) - 32'h1;
      if (!u && v[8*n-1]) v = v | ~m;
    end
    return v;
  endfunction

  // one clock: check at the falling edge, advance the model, then
  // present read data just after the rising edge
  task automatic tick();
    logic [31:0] ea;
    logic [3:0]  be;
    logic [31:0] wd;
    bit mis;
    bit slot;
    bit acc;
    int idx;
    @(negedge clk);
    chk(rsp_valid == (q_mis.size() != 0), "R8 response presence", 32'(rsp_valid), 32'(q_mis.size() != 0));
    if (rsp_valid && q_mis.size() != 0) begin
      chk(rsp_misalign == q_mis[0], {q_tag[0], " flag"}, 32'(rsp_misalign), 32'(q_mis[0]));
      chk(rsp_data == q_data[0], q_tag[0], rsp_data, q_data[0]);
    end
    if (hold_prev) begin
      chk(rsp_valid == 1'b1, "R9 held valid", 32'(rsp_valid), 32'd1);
      chk(rsp_data == prev_data && rsp_misalign == prev_mis, "R9 held data", rsp_data, prev_data);
    end
    ea   = ref_ea(req_base, req_offset);
    mis  = ref_mis(ea, req_size);
    slot = !rsp_valid || rsp_ready;
    chk(mem_valid == (req_valid && slot && !mis), "R10 mem_valid", 32'(mem_valid), 32'(req_valid && slot && !mis));
    chk(req_ready == (slot && (mis || mem_ready)), "R10 req_ready", 32'(req_ready), 32'(slot && (mis || mem_ready)));
    if (req_valid && mis) chk(!mem_valid, "R7 no memory access", 32'(mem_valid), 32'd0);
    if (mem_valid) begin
      chk(mem_addr == {ea[31:2], 2'b00}, "R1 address", mem_addr, {ea[31:2], 2'b00});
      chk(mem_write == req_store, "R10 mem_write", 32'(mem_write), 32'(req_store));
      if (req_store) begin
        be = ref_be(ea, req_size);
        wd = ref_wdata(req_wdata, req_size);
        chk(mem_be == be, "R2 byte enables", 32'(mem_be), 32'(be));
        chk(mem_wdata == wd, "R3 store lanes", mem_wdata, wd);
      end
    end
    acc = req_valid && req_ready;
    last_acc  = acc;
    hold_prev = rsp_valid && !rsp_ready;
    prev_data = rsp_data;
    prev_mis  = rsp_misalign;
    if (rsp_valid && rsp_ready && q_mis.size() != 0) begin
      void'(q_mis.pop_front());
      void'(q_data.pop_front());
      void'(q_tag.pop_front());
    end
    if (acc) begin
      idx = int'(ea[5:2]);
      if (mis) begin
        q_mis.push_back(1'b1); q_data.push_back('0); q_tag.push_back("R7 misaligned response");
      end else if (req_store) begin
        be = ref_be(ea, req_size);
        wd = ref_wdata(req_wdata, req_size);
        for (int j = 0; j < 4; j++)
          if (be[3-j]) mem_m[idx][31-8*j -: 8] = wd[31-8*j -: 8];
        q_mis.push_back(1'b0); q_data.push_back('0); q_tag.push_back("R8 store response");
      end else begin
        q_mis.push_back(1'b0);
        q_data.push_back(ref_load(mem_m[idx], ea, req_size, req_unsigned));
        if (nbytes(req_size) == 4) q_tag.push_back("R6 word load");
        else if (req_unsigned)     q_tag.push_back("R5 zero-extended load");
        else                       q_tag.push_back("R4 sign-extended load");
        rd_pend = 1;
        rd_word = mem_m[idx];
      end
    end
    @(posedge clk);
    #1;
    mem_rdata = rd_pend ? rd_word : $urandom();
    rd_pend = 0;
  endtask

  task automatic op(input bit st, input logic [1:0] sz, input bit u,
                    input logic [31:0] b, input logic [15:0] o, input logic [31:0] d);
    int guard;
    req_valid = 1; req_store = st; req_size = sz; req_unsigned = u;
    req_base = b; req_offset = o; req_wdata = d;
    guard = 0;
    do begin
      tick();
      guard++;
    end while (!last_acc && guard < 40);
    req_valid = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL R8 watchdog expired: actual=%h expected=%h", 32'd0, 32'd1);
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 16; i++) mem_m[i] = 32'h8F71_E6A2 + 32'(i) * 32'h0103_0507;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    chk(rsp_valid == 1'b0, "R11 reset rsp_valid", 32'(rsp_valid), 32'd0);
    chk(mem_valid == 1'b0, "R11 reset mem_valid", 32'(mem_valid), 32'd0);
    @(posedge clk); #1;

    // stores of every size and lane (R2, R3)
    op(1, 2'b10, 0, 32'h10, 16'h0, 32'h1122_3344);
    op(1, 2'b00, 0, 32'h10, 16'h1, 32'h0000_00A5);
    op(1, 2'b00, 0, 32'h13, 16'h0, 32'h0000_0081);
    op(1, 2'b01, 0, 32'h14, 16'h0, 32'h0000_F00D);
    op(1, 2'b01, 0, 32'h14, 16'h2, 32'h0000_7E57);
    // loads: signed and unsigned, each lane (R4, R5, R6)
    for (int k = 0; k < 4; k++) begin
      op(0, 2'b00, 0, 32'h10, 16'(k), '0);
      op(0, 2'b00, 1, 32'h10, 16'(k), '0);
    end
    op(0, 2'b01, 0, 32'h14, 16'h0, '0);
    op(0, 2'b01, 1, 32'h14, 16'h0, '0);
    op(0, 2'b01, 0, 32'h14, 16'h2, '0);
    op(0, 2'b10, 0, 32'h14, 16'h0, '0);
    // negative displacement (R1)
    op(0, 2'b10, 0, 32'h24, 16'hFFF0, '0);
    // misaligned accesses, then proof nothing was written (R7)
    op(0, 2'b01, 0, 32'h10, 16'h1, '0);
    op(0, 2'b10, 1, 32'h10, 16'h2, '0);
    op(1, 2'b10, 0, 32'h1B, 16'h0, 32'hFFFF_FFFF);
    op(0, 2'b10, 0, 32'h18, 16'h0, '0);
    // response stall over a load, released while the next request waits (R9)
    rsp_ready = 0;
    op(0, 2'b00, 0, 32'h10, 16'h3, '0);
    req_valid = 1; req_store = 0; req_size = 2'b10; req_base = 32'h10; req_offset = 16'h0;
    repeat (3) tick();
    rsp_ready = 1;
    tick();
    req_valid = 0;
    tick();
    // misaligned request arriving as a stalled response drains (R7, R9)
    rsp_ready = 0;
    op(0, 2'b01, 0, 32'h14, 16'h2, '0);
    req_valid = 1; req_size = 2'b10; req_base = 32'h11; req_offset = 16'h0;
    tick();
    rsp_ready = 1;
    tick();
    req_valid = 0;
    tick();
    // memory back-pressure (R10)
    mem_ready = 0;
    req_valid = 1; req_store = 1; req_size = 2'b00; req_base = 32'h20; req_wdata = 32'h5A;
    repeat (2) tick();
    mem_ready = 1;
    tick();
    req_valid = 0;
    tick();

    // random traffic with both stalls
    for (int c = 0; c < 4000; c++) begin
      req_valid    = ($urandom_range(0, 9) < 7);
      req_store    = $urandom_range(0, 1) == 1;
      req_size     = 2'($urandom_range(0, 2));
      req_unsigned = $urandom_range(0, 1) == 1;
      req_base     = 32'($urandom_range(8, 63));
      req_offset   = 16'($urandom_range(0, 16)) - 16'd8;
      req_wdata    = $urandom();
      rsp_ready    = ($urandom_range(0, 9) < 7);
      mem_ready    = ($urandom_range(0, 9) < 7);
      tick();
    end
    req_valid = 0; rsp_ready = 1;
    repeat (3) tick();

    finished = 1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule